// File: doc/BRIEF.md
# Output Setpoint Slew-Rate Ramp Controller

This block produces the reference code for a step-down regulator's output-voltage DAC. The output is 0.600 V plus the code times 6.25 mV, so a 7-bit code covers 0.600 V to 1.39375 V. Two code inputs hold candidate setpoints, and a select pin picks which one is the target. Changing either the select pin or the selected code retargets the block on the next clock.

When the target lies above the reference, the reference climbs by one code at a time. The step rate is set by a 3-bit slew code. Code 0 is the fastest, and each higher code doubles the step interval. When the target lies below the reference, the reference is held and switching is suppressed. The reference jumps to the target once an external comparator reports that the load has pulled the output down. After enable, a soft-start ramp climbs from code zero, with synchronous rectification inhibited. Flags report an upward or a downward transition in progress, and a one-cycle pulse marks arrival at the target.

Top module: `vref_ramp_ctrl`

## Requirements
- R1: `sel`=0 makes `code_lo` the target and `sel`=1 makes `code_hi` the target; a change of `sel` or of the selected code starts a new transition on the next clock.
- R2: While rising, `ref_code` changes only by +1. Successive steps are exactly BASE_DIV·2^`slew` clock cycles apart.
- R3: Each increment of the `slew` code (0 to 7) doubles the step interval, so code 0 is fastest and code 7 is 128 times slower.
- R4: When the target is below `ref_code`, `ref_code` is held and `sw_inhibit` and `dn_busy` stay high until `at_target` is sampled high. On that clock `ref_code` takes the target value.
- R5: A rising `en` starts a soft-start ramp from code 0 at the programmed rate. `up_busy` and `sync_rect_inhibit` are high during the soft-start. `sync_rect_inhibit` is low during ordinary upward ramps.
- R6: With `en` low, one clock later `ref_code` is 0 and every flag and `done` are low, whatever transition was running.
- R7: A target change during a transition continues from the present `ref_code`. A higher target keeps the step cadence. A target below `ref_code` turns the ramp into a held downward transition.
- R8: `done` is high for exactly one clock when `ref_code` reaches the target. In that cycle `up_busy` and `dn_busy` are low and `ref_code` equals the target.
- R9: After reset, `ref_code` is 0 and `up_busy`, `dn_busy`, `sw_inhibit`, `sync_rect_inhibit` and `done` are low.
- R10: Selecting a target equal to the present `ref_code` starts no transition and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable; rising edge starts soft-start |
| sel | input | 1 | Setpoint select: 0 picks code_lo, 1 picks code_hi |
| code_lo | input | CODE_W | Setpoint code used when sel is low |
| code_hi | input | CODE_W | Setpoint code used when sel is high |
| slew | input | SLEW_W | Upward rate code, 0 fastest, each step halves the rate |
| at_target | input | 1 | Comparator: output has fallen to the new setpoint |
| ref_code | output | CODE_W | Reference code to the DAC |
| sw_inhibit | output | 1 | Suppress switching during a downward transition |
| sync_rect_inhibit | output | 1 | Inhibit synchronous rectification during soft-start |
| up_busy | output | 1 | Upward or soft-start transition in progress |
| dn_busy | output | 1 | Downward transition in progress |
| done | output | 1 | One-clock pulse on reaching the target |

## Verification
The ramp is exercised with three slew codes, a soft-start from zero after enable, a setpoint swap through the select pin, and downward changes held for a long comparator delay. Measuring the interval between code changes separates a correct rate scaling from an off-by-one divider or a wrong shift. Retargeting during a ramp is tried in both directions. A higher target must keep the cadence with no restart, and a lower target must freeze the reference rather than count down. Dropping enable mid-ramp and selecting a target equal to the current code show that the block aborts cleanly and stays silent, respectively.

// File: rtl/vref_pkg.sv
package vref_pkg;

    typedef enum logic [2:0] {
        M_OFF  = 3'd0,
        M_SOFT = 3'd1,
        M_UP   = 3'd2,
        M_DOWN = 3'd3,
        M_IDLE = 3'd4
    } ramp_mode_e;

endpackage

// File: rtl/vref_target_sel.sv
module vref_target_sel #(
    parameter int CODE_W = 7
) (
    input  logic              sel,
    input  logic [CODE_W-1:0] code_lo,
    input  logic [CODE_W-1:0] code_hi,
    output logic [CODE_W-1:0] tgt
);

    always_comb begin
        tgt = sel ? code_hi : code_lo;
    end

endmodule

// File: rtl/vref_step_timer.sv
module vref_step_timer #(
    parameter int SLEW_W   = 3,
    parameter int BASE_DIV = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [SLEW_W-1:0] slew,
    output logic              tick
);

    localparam int N_RATE  = 2 ** SLEW_W;
    localparam int MAX_PER = BASE_DIV * (2 ** (N_RATE - 1));
    localparam int LIM_W   = $clog2(MAX_PER + 1);

    logic [LIM_W-1:0] lim_tab [N_RATE];
    logic [LIM_W-1:0] cnt_d, cnt_q;

    // one terminal count per rate code, each twice the previous
    generate
        for (genvar i = 0; i < N_RATE; i++) begin : g_rate
            assign lim_tab[i] = LIM_W'(BASE_DIV * (2 ** i) - 1);
        end
    endgenerate

    always_comb begin
        tick  = run && (cnt_q >= lim_tab[slew]);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/vref_ramp_ctrl.sv
module vref_ramp_ctrl
    import vref_pkg::*;
#(
    parameter int CODE_W   = 7,
    parameter int SLEW_W   = 3,
    parameter int BASE_DIV = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sel,
    input  logic [CODE_W-1:0] code_lo,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [SLEW_W-1:0] slew,
    input  logic              at_target,
    output logic [CODE_W-1:0] ref_code,
    output logic              sw_inhibit,
    output logic              sync_rect_inhibit,
    output logic              up_busy,
    output logic              dn_busy,
    output logic              done
);

    typedef struct packed {
        ramp_mode_e        mode;
        logic [CODE_W-1:0] ref_code;
        logic              done;
    } ramp_st_t;

    ramp_st_t          st_d, st_q;
    logic [CODE_W-1:0] tgt;
    logic              run;
    logic              tick;

    vref_target_sel #(.CODE_W(CODE_W)) u_sel (
        .sel     (sel),
        .code_lo (code_lo),
        .code_hi (code_hi),
        .tgt     (tgt)
    );

    assign run = en && ((st_q.mode == M_SOFT) || (st_q.mode == M_UP));

    vref_step_timer #(.SLEW_W(SLEW_W), .BASE_DIV(BASE_DIV)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .slew  (slew),
        .tick  (tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!en) begin
            st_d.mode     = M_OFF;
            st_d.ref_code = '0;
        end else begin
            unique case (st_q.mode)
                M_OFF: begin
                    st_d.mode     = M_SOFT;
                    st_d.ref_code = '0;
                end
                M_SOFT, M_UP: begin
                    if (st_q.ref_code == tgt) begin
                        st_d.mode = M_IDLE;
                        st_d.done = 1'b1;
                    end else if (st_q.ref_code > tgt) begin
                        st_d.mode = M_DOWN;
                    end else if (tick) begin
                        st_d.ref_code = st_q.ref_code + 1'b1;
                    end
                end
                M_DOWN: begin
                    if (tgt > st_q.ref_code) begin
                        st_d.mode = M_UP;
                    end else if (tgt == st_q.ref_code || at_target) begin
                        st_d.mode     = M_IDLE;
                        st_d.ref_code = tgt;
                        st_d.done     = 1'b1;
                    end
                end
                M_IDLE: begin
                    if (tgt > st_q.ref_code) begin
                        st_d.mode = M_UP;
                    end else if (tgt < st_q.ref_code) begin
                        st_d.mode = M_DOWN;
                    end
                end
                default: begin
                    st_d.mode     = M_OFF;
                    st_d.ref_code = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_OFF, ref_code: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_code          = st_q.ref_code;
    assign done              = st_q.done;
    assign up_busy           = (st_q.mode == M_SOFT) || (st_q.mode == M_UP);
    assign dn_busy           = (st_q.mode == M_DOWN);
    assign sw_inhibit        = (st_q.mode == M_DOWN);
    assign sync_rect_inhibit = (st_q.mode == M_SOFT);

endmodule

// File: rtl/vref_ramp_chk.sv
module vref_ramp_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              sel,
    input logic [CODE_W-1:0] code_lo,
    input logic [CODE_W-1:0] code_hi,
    input logic [CODE_W-1:0] ref_code,
    input logic              sw_inhibit,
    input logic              sync_rect_inhibit,
    input logic              up_busy,
    input logic              dn_busy,
    input logic              done
);

    // R2
    up_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(up_busy) && up_busy && (ref_code != $past(ref_code)))
        |-> (ref_code == CODE_W'($past(ref_code) + 1'b1)));

    // R4
    down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dn_busy) && dn_busy) |-> $stable(ref_code));

    // R4
    inhibit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_inhibit |-> (dn_busy && !up_busy));

    // R5
    soft_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rect_inhibit |-> (up_busy && !sw_inhibit));

    // R6
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((ref_code == '0) && !up_busy && !dn_busy && !done));

    // R8
    done_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!up_busy && !dn_busy
                  && (ref_code == $past(sel ? code_hi : code_lo))));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind vref_ramp_ctrl vref_ramp_chk #(.CODE_W(CODE_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .en                (en),
    .sel               (sel),
    .code_lo           (code_lo),
    .code_hi           (code_hi),
    .ref_code          (ref_code),
    .sw_inhibit        (sw_inhibit),
    .sync_rect_inhibit (sync_rect_inhibit),
    .up_busy           (up_busy),
    .dn_busy           (dn_busy),
    .done              (done)
);

// File: tb/sim_vref_ramp_ctrl.sv
`timescale 1ns/1ps
module sim_vref_ramp_ctrl;

    localparam int CW  = 7;
    localparam int SW  = 3;
    localparam int DIV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          sel = 1'b0;
    logic [CW-1:0] code_lo = '0;
    logic [CW-1:0] code_hi = '0;
    logic [SW-1:0] slew = '0;
    logic          at_target = 1'b0;
    logic [CW-1:0] ref_code;
    logic          sw_inhibit, sync_rect_inhibit, up_busy, dn_busy, done;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    code;
        int    gap;
        string tag;
    } item_t;
    item_t exp_q[$];

    always #4 clk = ~clk;

    vref_ramp_ctrl #(.CODE_W(CW), .SLEW_W(SW), .BASE_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .sel(sel),
        .code_lo(code_lo), .code_hi(code_hi), .slew(slew),
        .at_target(at_target), .ref_code(ref_code),
        .sw_inhibit(sw_inhibit), .sync_rect_inhibit(sync_rect_inhibit),
        .up_busy(up_busy), .dn_busy(dn_busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_ramp(input int from, input int to, input int per, input string tag);
        for (int v = from + 1; v <= to; v++) begin
            exp_q.push_back('{v, (v == from + 1) ? 0 : per, tag});
        end
    endtask

    task automatic wait_ref(input int v);
        for (int n = 0; n < 5000 && ref_code != CW'(v); n++) @(negedge clk);
    endtask

    task automatic wait_done(input string tag, input int exp_ref);
        for (int n = 0; n < 5000 && done !== 1'b1; n++) @(negedge clk);
        chk(done === 1'b1, {tag, " done pulse"}, int'(done), 1);
        chk(ref_code == CW'(exp_ref) && !up_busy && !dn_busy,
            {tag, " R8 ref at done"}, int'(ref_code), exp_ref);
        @(negedge clk);
        chk(done === 1'b0, "R8 done width", int'(done), 0);
    endtask

    // monitor: pop expected codes as the reference changes
    int       cyc = 0;
    int       last_chg = 0;
    logic [CW-1:0] last_ref = '0;
    always @(negedge clk) begin
        item_t it;
        cyc++;
        if (rst_n && ref_code !== last_ref) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected ref change", int'(ref_code), int'(last_ref));
            end else begin
                it = exp_q.pop_front();
                chk(int'(ref_code) == it.code, {it.tag, " ref code"}, int'(ref_code), it.code);
                if (it.gap != 0) begin
                    chk(cyc - last_chg == it.gap, {it.tag, " R2 step interval"},
                        cyc - last_chg, it.gap);
                end
            end
            last_ref = ref_code;
            last_chg = cyc;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(ref_code == 0 && !up_busy && !dn_busy && !sw_inhibit && !sync_rect_inhibit && !done,
            "R9 reset state", int'(ref_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 soft-start to code_lo at slew 0
        code_lo = 7'd10; code_hi = 7'd40; sel = 1'b0; slew = 3'd0;
        push_ramp(0, 10, DIV, "R5");
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk(up_busy && sync_rect_inhibit && !sw_inhibit, "R5 soft flags",
            int'(sync_rect_inhibit), 1);
        wait_done("R5", 10);

        // R1 select high, R3 slew code 1
        slew = 3'd1;
        push_ramp(10, 40, DIV * 2, "R1 R3");
        sel = 1'b1;
        repeat (2) @(negedge clk);
        chk(up_busy && !sync_rect_inhibit, "R5 no rect inhibit on up ramp",
            int'(sync_rect_inhibit), 0);
        wait_done("R1", 40);

        // R3 slew code 3
        slew = 3'd3;
        push_ramp(40, 45, DIV * 8, "R3");
        code_hi = 7'd45;
        wait_done("R3", 45);

        // R4 downward via select toggle, long comparator wait
        exp_q.push_back('{10, 0, "R4"});
        sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(dn_busy && sw_inhibit && !up_busy, "R4 down flags", int'(sw_inhibit), 1);
        repeat (20) @(negedge clk);
        chk(ref_code == 7'd45 && dn_busy, "R4 held", int'(ref_code), 45);
        at_target = 1'b1;
        @(negedge clk);
        at_target = 1'b0;
        wait_done("R4", 10);

        // R7 retarget higher mid-ramp keeps cadence
        slew = 3'd0;
        push_ramp(10, 20, DIV, "R7");
        code_lo = 7'd30;
        wait_ref(15);
        code_lo = 7'd20;
        wait_done("R7", 20);

        // R7 retarget below reference mid-ramp
        push_ramp(20, 25, DIV, "R7");
        code_lo = 7'd40;
        wait_ref(25);
        exp_q.push_back('{22, 0, "R7"});
        code_lo = 7'd22;
        repeat (3) @(negedge clk);
        chk(dn_busy && ref_code == 7'd25, "R7 turned to hold", int'(ref_code), 25);
        at_target = 1'b1;
        @(negedge clk);
        at_target = 1'b0;
        wait_done("R7", 22);

        // R10 target equal to reference
        code_hi = 7'd22;
        @(negedge clk);
        sel = 1'b1;
        begin
            int seen = 0;
            for (int n = 0; n < 12; n++) begin
                @(negedge clk);
                if (done || up_busy || dn_busy) seen++;
            end
            chk(seen == 0, "R10 no transition", seen, 0);
        end

        // R6 disable mid-ramp, then R5 restart from zero
        push_ramp(22, 28, DIV, "R6");
        code_hi = 7'd60;
        wait_ref(28);
        exp_q.push_back('{0, 0, "R6"});
        en = 1'b0;
        @(negedge clk);
        chk(ref_code == 0 && !up_busy && !dn_busy && !sync_rect_inhibit && !done,
            "R6 disabled state", int'(ref_code), 0);
        repeat (5) @(negedge clk);
        push_ramp(0, 60, DIV, "R5");
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk(sync_rect_inhibit && up_busy, "R5 restart soft flags", int'(sync_rect_inhibit), 1);
        wait_done("R5", 60);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected steps seen", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule